// File: doc/BRIEF.md
# Exception Entry Sequencer

This block computes where a processor goes when an exception is raised, and what the exception-related control state looks like afterwards. A one-cycle request carries an exception kind, the address of the faulting instruction, a delay-slot flag, a refill flag and a coprocessor number. The request also carries the current Status bits (EXL, ERL, BEV), the interrupt-vector select bit of Cause and the exception base register.

One clock edge later the block presents the following, and raises `done` for one cycle:
- the new program counter;
- the saved return addresses for the normal, error and debug levels;
- the exception code, branch-delay and coprocessor fields of Cause;
- the updated Status bits, the soft-reset and NMI flags;
- the kernel-mode and debug-mode indications.

The register owner copies these outputs back into its own state. Instruction execution, pipeline flushing and the return from an exception belong to other blocks.

The `kind` input codes are:
- 16 is an NMI.
- 17 is a soft reset.
- 19 is a debug exception.
- Every other value is a general exception whose ExcCode equals `kind`. For example, 0 is an interrupt, 2 and 3 are TLB load and store, 11 is coprocessor unusable and 30 is a cache error.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset every output is zero and `done` is low.
- R2: `done` is high exactly in the cycle after a cycle with `req` high, and outputs change only at that edge.
- R3: A general exception vectors to base+0x180. The base is 0xBFC00200 when `st_bev` is 1, and otherwise `ebase` with bits 9:0 cleared.
- R4: An interrupt (kind 0) uses offset 0x200 when `cause_iv` is 1, and 0x180 when it is 0.
- R5: A TLB load or store (kind 2 or 3) with `tlb_refill` high and `st_exl` low uses offset 0x000. With `st_exl` high or `tlb_refill` low it uses 0x180.
- R6: A cache error (kind 30) uses offset 0x100 when `st_bev` is 1, and 0x20000100 when it is 0.
- R7: A general exception writes `kind` into `exc_code`. Kind 11 also writes `cop_num` into `cause_ce`.
- R8: A general exception with `st_exl` low works as follows. If `in_delay` is 1, `epc` is `pc`-4 and `cause_bd` is 1. If `in_delay` is 0, `epc` is `pc` and `cause_bd` is 0. In both cases `exl_o` becomes 1.
- R9: A general exception with `st_exl` high leaves `epc` and `cause_bd` unchanged.
- R10: An NMI or soft reset works as follows:
  - `err_epc` follows the delay-slot rule of R8.
  - `erl_o` and `bev_o` are set, and the vector is 0xBFC00000.
  - An NMI sets `nmi_flag` and a soft reset sets `sr_flag`.
  - `cause_bd` is cleared when `st_exl` is low.
- R11: A debug exception stores `dbg_epc` under the delay-slot rule, sets `debug_mode` and vectors to 0xBFC00480.
- R12: Every accepted request sets `kmode` (kernel mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Exception request, one cycle |
| kind | input | 5 | Exception kind code |
| pc | input | 32 | Address of the faulting instruction |
| in_delay | input | 1 | Fault was in a branch delay slot |
| tlb_refill | input | 1 | TLB lookup found no matching entry |
| cop_num | input | 2 | Coprocessor number for coprocessor unusable |
| st_exl | input | 1 | Current exception level bit |
| st_erl | input | 1 | Current error level bit |
| st_bev | input | 1 | Current boot vector select bit |
| cause_iv | input | 1 | Interrupt vector select bit |
| ebase | input | 32 | Exception base register |
| done | output | 1 | Outputs updated this cycle |
| next_pc | output | 32 | New program counter |
| epc | output | 32 | Exception return address |
| err_epc | output | 32 | Error return address |
| dbg_epc | output | 32 | Debug return address |
| exc_code | output | 5 | Cause exception code field |
| cause_bd | output | 1 | Cause branch-delay bit |
| cause_ce | output | 2 | Cause coprocessor field |
| exl_o | output | 1 | Updated exception level bit |
| erl_o | output | 1 | Updated error level bit |
| bev_o | output | 1 | Updated boot vector bit |
| sr_flag | output | 1 | Soft reset indication |
| nmi_flag | output | 1 | NMI indication |
| kmode | output | 1 | Kernel mode forced |
| debug_mode | output | 1 | Debug mode entered |

## Verification
The bench targets four groups of corner cases.

Nested exceptions taken with EXL already set must keep the earlier return address and BD bit. A design that overwrote them would lose the outer return point.

The refill offset depends on both the refill flag and EXL. A design that ignored EXL would send nested refills to the refill vector instead of the general one.

Delay-slot faults must back the return address up by four at all three levels. The bench checks each level so that a missed subtraction shows as an address off by four.

The vector selection is checked with BEV, EBase (with nonzero low bits that must be masked), IV, and both cache-error offsets. A wrong base or offset gives a wrong `next_pc`.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] BOOT_BASE = 32'hBFC0_0200,
  parameter logic [AW-1:0] ERR_VEC = 32'hBFC0_0000,
  parameter logic [AW-1:0] DBG_VEC = 32'hBFC0_0480
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [4:0]    kind,
  input  logic [AW-1:0] pc,
  input  logic          in_delay,
  input  logic          tlb_refill,
  input  logic [1:0]    cop_num,
  input  logic          st_exl,
  input  logic          st_erl,
  input  logic          st_bev,
  input  logic          cause_iv,
  input  logic [AW-1:0] ebase,
  output logic          done,
  output logic [AW-1:0] next_pc,
  output logic [AW-1:0] epc,
  output logic [AW-1:0] err_epc,
  output logic [AW-1:0] dbg_epc,
  output logic [4:0]    exc_code,
  output logic          cause_bd,
  output logic [1:0]    cause_ce,
  output logic          exl_o,
  output logic          erl_o,
  output logic          bev_o,
  output logic          sr_flag,
  output logic          nmi_flag,
  output logic          kmode,
  output logic          debug_mode
);
  localparam logic [4:0] K_INT = 5'd0, K_TLBL = 5'd2, K_TLBS = 5'd3, K_CPU = 5'd11;
  localparam logic [4:0] K_NMI = 5'd16, K_SRST = 5'd17, K_DBG = 5'd19, K_CACHE = 5'd30;

  wire is_err = (kind == K_NMI) || (kind == K_SRST);
  wire is_dbg = (kind == K_DBG);
  wire is_gen = !is_err && !is_dbg;
  wire [AW-1:0] ret_pc = in_delay ? pc - AW'(4) : pc;
  wire [AW-1:0] gen_base = st_bev ? BOOT_BASE : {ebase[AW-1:10], 10'b0};

  logic [AW-1:0] gen_off;
  always_comb begin
    gen_off = AW'(32'h180);
    if (kind == K_INT && cause_iv) gen_off = AW'(32'h200);
    else if ((kind == K_TLBL || kind == K_TLBS) && tlb_refill && !st_exl) gen_off = '0;
    else if (kind == K_CACHE) gen_off = st_bev ? AW'(32'h100) : AW'(32'h2000_0100);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      next_pc <= '0;
      epc <= '0;
      err_epc <= '0;
      dbg_epc <= '0;
      exc_code <= '0;
      cause_bd <= 1'b0;
      cause_ce <= '0;
      exl_o <= 1'b0;
      erl_o <= 1'b0;
      bev_o <= 1'b0;
      sr_flag <= 1'b0;
      nmi_flag <= 1'b0;
      kmode <= 1'b0;
      debug_mode <= 1'b0;
    end else begin
      done <= req;
      if (req) begin
        kmode <= 1'b1;
        exl_o <= st_exl;
        erl_o <= st_erl;
        bev_o <= st_bev;
        if (is_gen) begin
          next_pc <= gen_base + gen_off;
          exc_code <= kind;
          if (kind == K_CPU) cause_ce <= cop_num;
          if (!st_exl) begin
            epc <= ret_pc;
            cause_bd <= in_delay;
          end
          exl_o <= 1'b1;
        end else if (is_err) begin
          next_pc <= ERR_VEC;
          err_epc <= ret_pc;
          erl_o <= 1'b1;
          bev_o <= 1'b1;
          if (kind == K_NMI) nmi_flag <= 1'b1;
          else sr_flag <= 1'b1;
          if (!st_exl) cause_bd <= 1'b0;
        end else begin
          next_pc <= DBG_VEC;
          dbg_epc <= ret_pc;
          debug_mode <= 1'b1;
          if (!st_exl) cause_bd <= 1'b0;
        end
      end
    end
  end
endmodule

module exc_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic [4:0]  kind,
  input logic        st_exl,
  input logic        done,
  input logic [31:0] next_pc,
  input logic [31:0] epc,
  input logic [4:0]  exc_code,
  input logic        cause_bd,
  input logic        exl_o,
  input logic        erl_o,
  input logic        bev_o,
  input logic        kmode,
  input logic        debug_mode
);
  wire gen = (kind != 5'd16) && (kind != 5'd17) && (kind != 5'd19);

  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done);
  assert_code_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req && gen |=> exc_code == $past(kind));
  assert_exl_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req && gen |=> exl_o);
  assert_epc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req && gen && st_exl |=> $stable(epc) && $stable(cause_bd));
  assert_err_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req && (kind == 5'd16 || kind == 5'd17) |=> next_pc == 32'hBFC0_0000 && erl_o && bev_o);
  assert_debug_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req && kind == 5'd19 |=> debug_mode && next_pc == 32'hBFC0_0480);
  assert_kernel_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> kmode);
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .kind(kind), .st_exl(st_exl),
  .done(done), .next_pc(next_pc), .epc(epc), .exc_code(exc_code),
  .cause_bd(cause_bd), .exl_o(exl_o), .erl_o(erl_o), .bev_o(bev_o),
  .kmode(kmode), .debug_mode(debug_mode)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [4:0] kind = '0;
  logic [31:0] pc = '0, ebase = '0;
  logic in_delay = 1'b0, tlb_refill = 1'b0, st_exl = 1'b0, st_erl = 1'b0, st_bev = 1'b0, cause_iv = 1'b0;
  logic [1:0] cop_num = '0;
  logic done, cause_bd, exl_o, erl_o, bev_o, sr_flag, nmi_flag, kmode, debug_mode;
  logic [31:0] next_pc, epc, err_epc, dbg_epc;
  logic [4:0] exc_code;
  logic [1:0] cause_ce;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .kind(kind), .pc(pc), .in_delay(in_delay),
    .tlb_refill(tlb_refill), .cop_num(cop_num), .st_exl(st_exl), .st_erl(st_erl),
    .st_bev(st_bev), .cause_iv(cause_iv), .ebase(ebase), .done(done), .next_pc(next_pc),
    .epc(epc), .err_epc(err_epc), .dbg_epc(dbg_epc), .exc_code(exc_code),
    .cause_bd(cause_bd), .cause_ce(cause_ce), .exl_o(exl_o), .erl_o(erl_o), .bev_o(bev_o),
    .sr_flag(sr_flag), .nmi_flag(nmi_flag), .kmode(kmode), .debug_mode(debug_mode)
  );

  task automatic chk(string req_tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req_tag, what, got, exp);
    end
  endtask

  task automatic fire(logic [4:0] k, logic [31:0] p, logic ds, logic rf, logic [1:0] cp,
                      logic exl, logic erl, logic bev, logic iv, logic [31:0] eb);
    @(negedge clk);
    kind = k; pc = p; in_delay = ds; tlb_refill = rf; cop_num = cp;
    st_exl = exl; st_erl = erl; st_bev = bev; cause_iv = iv; ebase = eb; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R2", "done", 32'(done), 32'd1);
    chk("R12", "kmode", 32'(kmode), 32'd1);
  endtask

  task automatic t_reset();
    chk("R1", "next_pc", next_pc, 0);
    chk("R1", "epc", epc, 0);
    chk("R1", "flags", {19'b0, done, exl_o, erl_o, bev_o, sr_flag, nmi_flag, kmode, debug_mode, exc_code}, 0);
  endtask

  task automatic t_general();
    fire(5'd8, 32'h1000, 0, 0, 0, 0, 0, 1, 0, 32'h8000_0000);
    chk("R3", "bev vector", next_pc, 32'hBFC0_0380);
    chk("R7", "code", 32'(exc_code), 8);
    chk("R8", "epc", epc, 32'h1000);
    chk("R8", "bd", 32'(cause_bd), 0);
    chk("R8", "exl", 32'(exl_o), 1);
    @(negedge clk);
    chk("R2", "done drop", 32'(done), 0);
    fire(5'd12, 32'h1100, 0, 0, 0, 0, 0, 0, 0, 32'h8000_1234);
    chk("R3", "ebase vector", next_pc, 32'h8000_1180);
    chk("R7", "code", 32'(exc_code), 12);
  endtask

  task automatic t_interrupt();
    fire(5'd0, 32'h1200, 0, 0, 0, 0, 0, 0, 1, 32'h8000_0000);
    chk("R4", "iv vector", next_pc, 32'h8000_0200);
    chk("R4", "code", 32'(exc_code), 0);
    fire(5'd0, 32'h1200, 0, 0, 0, 0, 0, 0, 0, 32'h8000_0000);
    chk("R4", "no iv vector", next_pc, 32'h8000_0180);
  endtask

  task automatic t_refill();
    fire(5'd2, 32'h1300, 0, 1, 0, 0, 0, 0, 0, 32'h8000_0000);
    chk("R5", "refill vector", next_pc, 32'h8000_0000);
    fire(5'd3, 32'h1300, 0, 1, 0, 1, 0, 0, 0, 32'h8000_0000);
    chk("R5", "nested refill", next_pc, 32'h8000_0180);
    chk("R7", "code", 32'(exc_code), 3);
    fire(5'd2, 32'h1300, 0, 0, 0, 0, 0, 0, 0, 32'h8000_0000);
    chk("R5", "invalid vector", next_pc, 32'h8000_0180);
  endtask

  task automatic t_cache();
    fire(5'd30, 32'h1400, 0, 0, 0, 0, 0, 1, 0, 32'h8000_0000);
    chk("R6", "bev cache", next_pc, 32'hBFC0_0300);
    fire(5'd30, 32'h1400, 0, 0, 0, 0, 0, 0, 0, 32'h8000_0000);
    chk("R6", "ebase cache", next_pc, 32'hA000_0100);
  endtask

  task automatic t_cop();
    fire(5'd11, 32'h1500, 0, 0, 2'd2, 0, 0, 0, 0, 32'h8000_0000);
    chk("R7", "ce", 32'(cause_ce), 2);
    chk("R7", "code", 32'(exc_code), 11);
  endtask

  task automatic t_delay_and_hold();
    fire(5'd10, 32'h2008, 1, 0, 0, 0, 0, 0, 0, 32'h8000_0000);
    chk("R8", "ds epc", epc, 32'h2004);
    chk("R8", "ds bd", 32'(cause_bd), 1);
    fire(5'd9, 32'h5000, 0, 0, 0, 1, 0, 0, 0, 32'h8000_0000);
    chk("R9", "epc held", epc, 32'h2004);
    chk("R9", "bd held", 32'(cause_bd), 1);
    chk("R7", "code", 32'(exc_code), 9);
  endtask

  task automatic t_nmi_srst();
    fire(5'd16, 32'h3010, 1, 0, 0, 0, 0, 0, 0, 32'h8000_0000);
    chk("R10", "nmi vector", next_pc, 32'hBFC0_0000);
    chk("R10", "nmi errepc", err_epc, 32'h300C);
    chk("R10", "erl bev nmi", {29'b0, erl_o, bev_o, nmi_flag}, 7);
    chk("R10", "bd cleared", 32'(cause_bd), 0);
    fire(5'd17, 32'h4000, 0, 0, 0, 0, 0, 0, 0, 32'h8000_0000);
    chk("R10", "srst errepc", err_epc, 32'h4000);
    chk("R10", "sr flag", 32'(sr_flag), 1);
  endtask

  task automatic t_debug();
    fire(5'd19, 32'h6004, 1, 0, 0, 0, 0, 0, 0, 32'h8000_0000);
    chk("R11", "debug vector", next_pc, 32'hBFC0_0480);
    chk("R11", "depc", dbg_epc, 32'h6000);
    chk("R11", "debug mode", 32'(debug_mode), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_general();
    t_interrupt();
    t_refill();
    t_cache();
    t_cop();
    t_delay_and_hold();
    t_nmi_srst();
    t_debug();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule